// File: doc/BRIEF.md
# Reset and Default-Load Sequencer

This block fills a small bank of control registers with factory default words and keeps them there. After power-up it waits for two conditions: the supplies must be reported good and the converter clock must be reported present. It then starts a reset window that lasts a fixed number of converter clock cycles. Early in that window it reads the default words one by one from a synchronous ROM port and writes each word into the matching register. When the window closes, `done` rises and the serial interface may change the registers.

Software can start the same sequence again by writing the value 0x5A to the special address 0x10. During the window, `busy` is high and ordinary serial writes are dropped. If the supply-good indication goes low, the sequencer drops back to waiting. It runs a complete, fresh load once the indication returns.

Top module: `rst_load_seq`

## Requirements
- R1: While `rst` is high, and on the first sample after it is released with `pwr_good` low, `busy`, `done` and `rom_rd` are all 0.
- R2: No load starts while `pwr_good` or `clk_present` is low. `busy` stays 0 until both have been seen high at one clock edge.
- R3: `busy` rises on the edge after the start condition and stays high for exactly RESET_CYCLES clock cycles (default 20750, which is 415 µs at 50 MHz). On the edge that clears `busy`, `done` is set. `busy` and `done` are never high together.
- R4: During a load the block reads ROM addresses 0 up to NUM_REGS-1 in ascending order with `rom_rd` high. The ROM returns data one cycle after each request. Register i then holds the ROM word at address i.
- R5: When `done` is high, a serial write (`wr_en` high) to an address below NUM_REGS updates that register. `rd_data` returns the register selected by `rd_addr` one cycle after `rd_addr` is applied.
- R6: Serial writes made while `busy` is high have no effect. This covers writes to ordinary registers and the 0x5A restart command.
- R7: When `done` is high, writing 0x5A to address 0x10 clears `done` and raises `busy` on the next edge. The full load then runs again and restores every register to its ROM default.
- R8: A write to address 0x10 with any data other than 0x5A has no effect. A write to any address from NUM_REGS to 31 other than 0x10 also has no effect.
- R9: When `pwr_good` is low at an edge, `busy` and `done` are 0 after that edge. When it returns, a complete new load runs.
- R10: While `done` and `pwr_good` stay high and no write occurs, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supplies valid |
| clk_present | input | 1 | Input clock detected |
| wr_en | input | 1 | Serial write strobe |
| wr_addr | input | ADDR_W | Serial write address |
| wr_data | input | DATA_W | Serial write data |
| rd_addr | input | RA_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| rom_rd | output | 1 | Default ROM read request |
| rom_addr | output | RA_W | Default ROM address |
| rom_data | input | DATA_W | Default ROM data, one cycle after request |
| busy | output | 1 | Reset window active |
| done | output | 1 | Defaults loaded, registers writable |

## Verification
The bench counts `busy` cycles on every load: the first load, the restart command, and a restart after a supply drop. A design with an off-by-one window, or one that restarts its counter on a second 0x5A, gives the wrong count. The bench sweeps every register after each load and after each ignored stimulus. A skewed ROM pipeline shows up as shifted defaults, and a leaky address decode shows up as a corrupted register. Writes are aimed at the busy window after the ROM copy has finished, so a design that lets them through leaves the written value in place. The bench also drops supplies both during a load and after it, and expects the flags to fall on the next edge.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_READY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rls_seq_ctrl.sv
module rls_seq_ctrl
  import rls_pkg::*;
#(
  parameter int RESET_CYCLES = 20750,
  parameter int CNT_W        = $clog2(RESET_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             clk_present,
  input  logic             soft_req,
  output seq_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RESET_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      state <= ST_WAIT;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (clk_present) begin
            state <= ST_LOAD;
            cnt   <= '0;
            busy  <= 1'b1;
          end
        end
        ST_LOAD: begin
          if (cnt == LAST) begin
            state <= ST_READY;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READY: begin
          if (soft_req) begin
            state <= ST_LOAD;
            cnt   <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !(pwr_good && clk_present)) |=> !busy);
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(cnt) < RESET_CYCLES));
  assert_supply_loss_R9: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!busy && !done));
  assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (done && pwr_good && !soft_req) |=> done);
endmodule

// File: rtl/rls_fetch.sv
module rls_fetch #(
  parameter int NUM_REGS = 16,
  parameter int RA_W     = $clog2(NUM_REGS),
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  output logic             rom_rd,
  output logic [RA_W-1:0]  rom_addr,
  output logic             fill_vld,
  output logic [RA_W-1:0]  fill_addr
);
  localparam logic [CNT_W-1:0] FETCH_END = CNT_W'(NUM_REGS);

  always_comb begin
    rom_rd   = busy && (cnt < FETCH_END);
    rom_addr = cnt[RA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_vld  <= 1'b0;
      fill_addr <= '0;
    end else begin
      fill_vld  <= rom_rd;
      fill_addr <= rom_addr;
    end
  end

  assert_fetch_range_R4: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> (int'(rom_addr) < NUM_REGS));
  assert_fetch_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_vld && $past(fill_vld)) |-> (fill_addr == $past(fill_addr) + 1'b1));
endmodule

// File: rtl/rls_regfile.sv
module rls_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int RA_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rst_load_seq.sv
module rst_load_seq
  import rls_pkg::*;
#(
  parameter int          NUM_REGS     = 16,
  parameter int          DATA_W       = 8,
  parameter int          ADDR_W       = 5,
  parameter int          RESET_CYCLES = 20750,
  parameter int          SFR_ADDR     = 16,
  parameter int          MAGIC        = 8'h5A,
  parameter int          RA_W         = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              clk_present,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rom_rd,
  output logic [RA_W-1:0]   rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(RESET_CYCLES);
  localparam logic [ADDR_W-1:0] SFR_A   = ADDR_W'(SFR_ADDR);
  localparam logic [ADDR_W-1:0] REG_END = ADDR_W'(NUM_REGS);
  localparam logic [DATA_W-1:0] KEY     = DATA_W'(MAGIC);

  initial begin
    if (RESET_CYCLES < NUM_REGS + 2) $error("reset window shorter than the copy");
    if (SFR_ADDR < NUM_REGS) $error("special address overlaps registers");
  end

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             soft_req, user_we;
  logic             fill_vld;
  logic [RA_W-1:0]  fill_addr;
  logic             rf_we;
  logic [RA_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  always_comb begin
    soft_req = wr_en && done && (wr_addr == SFR_A) && (wr_data == KEY);
    user_we  = wr_en && done && (wr_addr < REG_END);
    rf_we    = fill_vld || user_we;
    rf_waddr = fill_vld ? fill_addr : wr_addr[RA_W-1:0];
    rf_wdata = fill_vld ? rom_data  : wr_data;
  end

  rls_seq_ctrl #(.RESET_CYCLES(RESET_CYCLES), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_present(clk_present),
    .soft_req(soft_req), .state(state), .cnt(cnt), .busy(busy), .done(done)
  );

  rls_fetch #(.NUM_REGS(NUM_REGS), .RA_W(RA_W), .CNT_W(CNT_W)) i_fetch (
    .clk(clk), .rst(rst), .busy(busy), .cnt(cnt), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .fill_vld(fill_vld), .fill_addr(fill_addr)
  );

  rls_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RA_W(RA_W)) i_regs (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (soft_req && pwr_good) |=> (busy && !done));
  assert_no_user_write_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> (busy || done || !$past(pwr_good)) && (state != ST_READY || $past(cnt) == CNT_W'(RESET_CYCLES - 1)));
  assert_idle_no_rom_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rom_rd);
endmodule

// File: tb/test_rst_load_seq.sv
module test_rst_load_seq;
  localparam int NR = 16, DW = 8, AW = 5, RC = 40, RA = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, pwr_good, clk_present, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, rom_data, rd_data;
  logic [RA-1:0] rd_addr, rom_addr;
  logic rom_rd, busy, done;

  int total = 0, bad = 0, bc = 0;
  logic [DW-1:0] shadow [NR];

  rst_load_seq #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .RESET_CYCLES(RC)) i_rst_load_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_present(clk_present),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .busy(busy), .done(done)
  );

  function automatic logic [DW-1:0] dflt(input int a);
    return DW'(a * 29 + 8'h35);
  endfunction

  always @(posedge clk) begin
    if (rom_rd) rom_data <= dflt(int'(rom_addr));
    if (busy) bc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    tick;
    wr_en = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < NR; a++) begin
      rd_addr = RA'(a);
      tick;
      chk(rd_data == shadow[a], req, rd_data, shadow[a]);
    end
  endtask

  task automatic load_dflt;
    for (int a = 0; a < NR; a++) shadow[a] = dflt(a);
  endtask

  task automatic wait_done;
    for (int k = 0; k < 4 * RC && !done; k++) tick;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_good = 1'b0; clk_present = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) tick;
    chk(!busy && !done && !rom_rd, "R1 in reset", {busy, done, rom_rd}, 0);
    rst = 1'b0;
    tick;
    chk(!busy && !done && !rom_rd, "R1 after release", {busy, done, rom_rd}, 0);

    clk_present = 1'b1;
    repeat (6) tick;
    chk(!busy, "R2 clock only", busy, 0);
    pwr_good = 1'b1; clk_present = 1'b0;
    repeat (6) tick;
    chk(!busy, "R2 supply only", busy, 0);

    bc = 0;
    clk_present = 1'b1;
    tick;
    chk(busy && !done, "R3 busy rises", {busy, done}, 2);
    wait_done;
    chk(bc == RC, "R3 first window length", bc, RC);
    chk(done && !busy, "R3 done at end", {busy, done}, 1);
    load_dflt;
    sweep("R4 defaults after power-up");

    for (int a = 0; a < NR; a++) begin
      shadow[a] = DW'(8'hA0 ^ (a * 7));
      wr(a, shadow[a]);
    end
    sweep("R5 user writes");

    wr(16, 8'h5B);
    wr(16, 8'h00);
    chk(!busy && done, "R8 wrong key", {busy, done}, 1);
    for (int a = NR; a < 32; a++) if (a != 16) wr(a, 8'hC3);
    sweep("R8 unused addresses");

    repeat (50) tick;
    sweep("R10 hold while idle");

    bc = 0;
    wr(16, 8'h5A);
    chk(busy && !done, "R7 restart flags", {busy, done}, 2);
    repeat (25) tick;
    wr(3, 8'hEE);
    wr(16, 8'h5A);
    wait_done;
    chk(bc == RC, "R6 R7 window not extended", bc, RC);
    load_dflt;
    sweep("R6 R7 defaults restored");

    wr(5, 8'h77); shadow[5] = 8'h77;
    pwr_good = 1'b0;
    tick;
    chk(!busy && !done, "R9 drop when ready", {busy, done}, 0);
    pwr_good = 1'b1;
    wait_done;
    wr(16, 8'h5A);
    repeat (10) tick;
    pwr_good = 1'b0;
    tick;
    chk(!busy && !done, "R9 drop during load", {busy, done}, 0);
    repeat (4) tick;
    bc = 0;
    pwr_good = 1'b1;
    tick;
    wait_done;
    chk(bc == RC, "R9 fresh window", bc, RC);
    load_dflt;
    sweep("R9 defaults after return");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule